// File: doc/BRIEF.md
# Merging Store Buffer with Load Forwarding

This block sits between a load/store unit and a memory port and holds recent stores for a while before they reach memory. Every store names an aligned 8-byte word, a byte-enable mask, lane-aligned data and a flag that marks it as Device (side-effect) memory rather than Normal memory. A Normal store that lands in the same word as the youngest buffered entry for that word joins that entry byte by byte, so several narrow stores can leave as one masked write. Device stores always take their own entry and are sent out at once.

Loads are checked against the buffer. If every requested byte is held, the newest copy of each byte is returned without touching memory. If no requested byte is held, the word is read from memory. If the buffer holds only some of the requested bytes, the load is held off and the buffer drains until none of them remain, and then the load reads memory. A flush input drains the whole buffer. The idle output shows when it is empty.

All data paths use valid/ready. A source holds valid and its payload steady until ready is seen high at a rising clock edge. The block holds its own write-request and read-request payloads the same way. Read responses are always accepted. The store and load channels stall by dropping ready. A load and a store accepted in the same cycle are treated as the load being older.

Top module: `merging_store_buffer`

## Requirements
- R1: After reset, idle is 1, st_ready is 1 while flush is 0, and mem_wr_valid, mem_rd_valid and ld_rsp_valid are 0.
- R2: A store that cannot merge allocates a new entry. st_ready is 0 while all DEPTH entries are in use and the store cannot merge, and also while flush is 1.
- R3: A Normal store merges into the youngest entry holding the same word address if that entry is Normal and is not the oldest entry currently offered on the write channel. After merging, each byte holds the newest data, and the merged entry leaves as one write whose strobe is the union of the byte masks (bit b of a strobe covers bits 8b+7..8b of the data).
- R4: A Device store never merges and no store merges into a Device entry. Each Device store produces its own memory write.
- R5: Entries leave in allocation order. A write is offered only when the buffer is full, flush is 1, the oldest entry is Device, or a load is waiting on partial coverage.
- R6: Once mem_wr_valid is 1 with mem_wr_ready 0, the valid, address, strobe and data stay unchanged until the write is accepted.
- R7: A load whose requested bytes are all held in the buffer gets ld_rsp_valid one cycle after acceptance. Each byte comes from the youngest entry that holds it, and no memory read is issued.
- R8: A load with no requested byte held issues one memory read for its word. Its response carries the memory bytes in the requested lanes and zero in all others.
- R9: A load with some but not all requested bytes held keeps ld_ready at 0 and drives draining until no requested byte is held. It then completes through memory.
- R10: Memory ends in the same state as if all stores had been applied in program order. No buffered write is first offered while a memory read is outstanding.
- R11: While flush is 1 the buffer empties completely. idle is 1 exactly when no entry is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted when high with st_valid |
| st_waddr | input | WADDR_W | Word address of the store |
| st_strb | input | NB | Byte enables of the store |
| st_data | input | NB*8 | Lane-aligned store data |
| st_dev | input | 1 | 1 = Device memory, 0 = Normal memory |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted when high with ld_valid |
| ld_waddr | input | WADDR_W | Word address of the load |
| ld_strb | input | NB | Bytes requested by the load |
| ld_rsp_valid | output | 1 | One-cycle pulse carrying load data |
| ld_rsp_data | output | NB*8 | Load data, unrequested lanes zero |
| mem_wr_valid | output | 1 | Memory write request valid |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_waddr | output | WADDR_W | Write word address |
| mem_wr_strb | output | NB | Write byte strobes |
| mem_wr_data | output | NB*8 | Write data |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_waddr | output | WADDR_W | Read word address |
| mem_rd_rsp_valid | input | 1 | Read data returned |
| mem_rd_rsp_data | input | NB*8 | Returned word |
| flush | input | 1 | Level request to drain all entries |
| idle | output | 1 | Buffer holds no entry |

## Verification
The bench uses the defaults: DEPTH of 4, eight byte lanes and a 29-bit word address. Four entries are few enough that four stores to distinct words fill the buffer. This brings several cases within reach: the full-buffer stall, the drain triggered by a full buffer, a merge into a younger entry while the oldest is held on a stalled write channel, and the refusal to merge into that held oldest entry. With eight lanes, wide and narrow stores can overlap within one word, so forwarding that mixes bytes from a Normal entry and a younger Device entry can be checked.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2
  } ld_state_e;
endpackage

// File: rtl/sbuf_merge_sel.sv
module sbuf_merge_sel #(
  parameter int DEPTH   = 4,
  parameter int WADDR_W = 29,
  parameter int PTR_W   = 2
) (
  input  logic [PTR_W-1:0]              head,
  input  logic [PTR_W:0]                count,
  input  logic [DEPTH-1:0][WADDR_W-1:0] e_waddr,
  input  logic [DEPTH-1:0]              e_dev,
  input  logic [WADDR_W-1:0]            st_waddr,
  input  logic                          st_dev,
  input  logic                          head_lock,
  output logic                          merge_ok,
  output logic [PTR_W-1:0]              merge_idx
);
  logic             found;
  logic [PTR_W-1:0] tgt;

  // youngest matching entry wins: scan oldest to youngest, keep last hit
  always_comb begin
    logic [PTR_W-1:0] idx;
    found = 1'b0;
    tgt   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (k < int'(count) && e_waddr[idx] == st_waddr) begin
        found = 1'b1;
        tgt   = idx;
      end
    end
  end

  assign merge_ok  = found && !e_dev[tgt] && !st_dev && !(head_lock && tgt == head);
  assign merge_idx = tgt;
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd #(
  parameter int DEPTH   = 4,
  parameter int WADDR_W = 29,
  parameter int PTR_W   = 2,
  parameter int NB      = 8
) (
  input  logic [PTR_W-1:0]              head,
  input  logic [PTR_W:0]                count,
  input  logic [DEPTH-1:0][WADDR_W-1:0] e_waddr,
  input  logic [DEPTH-1:0][NB-1:0]      e_mask,
  input  logic [DEPTH-1:0][NB*8-1:0]    e_data,
  input  logic [WADDR_W-1:0]            ld_waddr,
  input  logic [NB-1:0]                 ld_strb,
  output logic [NB*8-1:0]               fwd_data,
  output logic                          cov_full,
  output logic                          cov_any
);
  logic [NB-1:0] cov;

  always_comb begin
    logic [PTR_W-1:0] idx;
    fwd_data = '0;
    cov      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PTR_W'(k);
      if (k < int'(count) && e_waddr[idx] == ld_waddr) begin
        for (int b = 0; b < NB; b++) begin
          if (e_mask[idx][b]) begin
            fwd_data[b*8 +: 8] = e_data[idx][b*8 +: 8];
            cov[b]             = 1'b1;
          end
        end
      end
    end
  end

  assign cov_full = (ld_strb & ~cov) == '0;
  assign cov_any  = |(ld_strb & cov);
endmodule

// File: rtl/sbuf_ldctl.sv
module sbuf_ldctl
  import sbuf_pkg::*;
#(
  parameter int WADDR_W = 29,
  parameter int NB      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [WADDR_W-1:0] ld_waddr,
  input  logic [NB-1:0]      ld_strb,
  output logic               ld_rsp_valid,
  output logic [NB*8-1:0]    ld_rsp_data,
  input  logic [NB*8-1:0]    fwd_data,
  input  logic               cov_full,
  input  logic               cov_any,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [WADDR_W-1:0] mem_rd_waddr,
  input  logic               mem_rd_rsp_valid,
  input  logic [NB*8-1:0]    mem_rd_rsp_data,
  output logic               rd_busy,
  output logic               part_wait
);
  ld_state_e          st_q;
  logic [WADDR_W-1:0] sv_waddr;
  logic [NB-1:0]      sv_strb;
  logic               rsp_valid_q;
  logic [NB*8-1:0]    rsp_data_q;

  function automatic logic [NB*8-1:0] keep_lanes(input logic [NB*8-1:0] d,
                                                  input logic [NB-1:0] m);
    logic [NB*8-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = m[b] ? d[b*8 +: 8] : 8'h00;
    return r;
  endfunction

  assign ld_ready     = (st_q == LD_IDLE) && (cov_full || !cov_any);
  assign part_wait    = (st_q == LD_IDLE) && ld_valid && cov_any && !cov_full;
  assign rd_busy      = (st_q != LD_IDLE);
  assign mem_rd_valid = (st_q == LD_REQ);
  assign mem_rd_waddr = sv_waddr;
  assign ld_rsp_valid = rsp_valid_q;
  assign ld_rsp_data  = rsp_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= LD_IDLE;
      sv_waddr    <= '0;
      sv_strb     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        LD_IDLE: begin
          if (ld_valid && ld_ready) begin
            if (cov_full) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= keep_lanes(fwd_data, ld_strb);
            end else begin
              st_q     <= LD_REQ;
              sv_waddr <= ld_waddr;
              sv_strb  <= ld_strb;
            end
          end
        end
        LD_REQ: if (mem_rd_ready) st_q <= LD_WAIT;
        LD_WAIT: begin
          if (mem_rd_rsp_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= keep_lanes(mem_rd_rsp_data, sv_strb);
            st_q        <= LD_IDLE;
          end
        end
        default: st_q <= LD_IDLE;
      endcase
    end
  end

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_waddr));

  assert_fwd_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && cov_full |=> !mem_rd_valid && ld_rsp_valid);
endmodule

// File: rtl/merging_store_buffer.sv
module merging_store_buffer #(
  parameter int DEPTH   = 4,
  parameter int WADDR_W = 29,
  parameter int NB      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [WADDR_W-1:0]   st_waddr,
  input  logic [NB-1:0]        st_strb,
  input  logic [NB*8-1:0]      st_data,
  input  logic                 st_dev,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic [WADDR_W-1:0]   ld_waddr,
  input  logic [NB-1:0]        ld_strb,
  output logic                 ld_rsp_valid,
  output logic [NB*8-1:0]      ld_rsp_data,
  output logic                 mem_wr_valid,
  input  logic                 mem_wr_ready,
  output logic [WADDR_W-1:0]   mem_wr_waddr,
  output logic [NB-1:0]        mem_wr_strb,
  output logic [NB*8-1:0]      mem_wr_data,
  output logic                 mem_rd_valid,
  input  logic                 mem_rd_ready,
  output logic [WADDR_W-1:0]   mem_rd_waddr,
  input  logic                 mem_rd_rsp_valid,
  input  logic [NB*8-1:0]      mem_rd_rsp_data,
  input  logic                 flush,
  output logic                 idle
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam int DW    = NB * 8;

  logic [DEPTH-1:0][WADDR_W-1:0] e_waddr;
  logic [DEPTH-1:0][NB-1:0]      e_mask;
  logic [DEPTH-1:0][DW-1:0]      e_data;
  logic [DEPTH-1:0]              e_dev;
  logic [PTR_W-1:0]              head, tail;
  logic [CNT_W-1:0]              count;
  logic                          hold_q;

  logic             merge_ok;
  logic [PTR_W-1:0] merge_idx;
  logic [DW-1:0]    fwd_data;
  logic             cov_full, cov_any;
  logic             rd_busy, part_wait;
  logic             st_fire, alloc, merge_fire, pop, full, want_drain;

  assign full       = (count == CNT_W'(DEPTH));
  assign st_ready   = !flush && (merge_ok || !full);
  assign st_fire    = st_valid && st_ready;
  assign merge_fire = st_fire && merge_ok;
  assign alloc      = st_fire && !merge_ok;
  assign pop        = mem_wr_valid && mem_wr_ready;
  assign idle       = (count == '0);

  // lazy drain: only when pressure or ordering calls for it
  assign want_drain   = !idle && (full || flush || part_wait || e_dev[head]);
  assign mem_wr_valid = hold_q || (want_drain && !rd_busy);
  assign mem_wr_waddr = e_waddr[head];
  assign mem_wr_strb  = e_mask[head];
  assign mem_wr_data  = e_data[head];

  sbuf_merge_sel #(.DEPTH(DEPTH), .WADDR_W(WADDR_W), .PTR_W(PTR_W)) u_merge_sel (
    .head      (head),
    .count     (count),
    .e_waddr   (e_waddr),
    .e_dev     (e_dev),
    .st_waddr  (st_waddr),
    .st_dev    (st_dev),
    .head_lock (mem_wr_valid),
    .merge_ok  (merge_ok),
    .merge_idx (merge_idx)
  );

  sbuf_fwd #(.DEPTH(DEPTH), .WADDR_W(WADDR_W), .PTR_W(PTR_W), .NB(NB)) u_fwd (
    .head     (head),
    .count    (count),
    .e_waddr  (e_waddr),
    .e_mask   (e_mask),
    .e_data   (e_data),
    .ld_waddr (ld_waddr),
    .ld_strb  (ld_strb),
    .fwd_data (fwd_data),
    .cov_full (cov_full),
    .cov_any  (cov_any)
  );

  sbuf_ldctl #(.WADDR_W(WADDR_W), .NB(NB)) u_ldctl (
    .clk              (clk),
    .rst_n            (rst_n),
    .ld_valid         (ld_valid),
    .ld_ready         (ld_ready),
    .ld_waddr         (ld_waddr),
    .ld_strb          (ld_strb),
    .ld_rsp_valid     (ld_rsp_valid),
    .ld_rsp_data      (ld_rsp_data),
    .fwd_data         (fwd_data),
    .cov_full         (cov_full),
    .cov_any          (cov_any),
    .mem_rd_valid     (mem_rd_valid),
    .mem_rd_ready     (mem_rd_ready),
    .mem_rd_waddr     (mem_rd_waddr),
    .mem_rd_rsp_valid (mem_rd_rsp_valid),
    .mem_rd_rsp_data  (mem_rd_rsp_data),
    .rd_busy          (rd_busy),
    .part_wait        (part_wait)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      count  <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= mem_wr_valid && !mem_wr_ready;
      if (pop)   head <= head + PTR_W'(1);
      if (alloc) tail <= tail + PTR_W'(1);
      count <= count + CNT_W'(alloc) - CNT_W'(pop);
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_waddr[gi] <= '0;
        e_mask[gi]  <= '0;
        e_data[gi]  <= '0;
        e_dev[gi]   <= 1'b0;
      end else if (alloc && tail == PTR_W'(gi)) begin
        e_waddr[gi] <= st_waddr;
        e_mask[gi]  <= st_strb;
        e_data[gi]  <= st_data;
        e_dev[gi]   <= st_dev;
      end else if (merge_fire && merge_idx == PTR_W'(gi)) begin
        e_mask[gi] <= e_mask[gi] | st_strb;
        for (int b = 0; b < NB; b++)
          if (st_strb[b]) e_data[gi][b*8 +: 8] <= st_data[b*8 +: 8];
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_waddr)
      && $stable(mem_wr_strb) && $stable(mem_wr_data));

  assert_read_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy && mem_wr_valid |-> $past(mem_wr_valid && !mem_wr_ready));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_wr_valid);

  assert_dev_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_dev |=> (count != $past(count)) || $past(pop));
endmodule

// File: tb/merging_store_buffer_bench.sv
`timescale 1ns/1ps
module merging_store_buffer_bench;
  localparam int DEPTH = 4;
  localparam int WA    = 29;
  localparam int NB    = 8;
  localparam int DW    = NB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          st_valid = 0, st_dev = 0;
  logic [WA-1:0] st_waddr = '0;
  logic [NB-1:0] st_strb = '0;
  logic [DW-1:0] st_data = '0;
  logic          st_ready;
  logic          ld_valid = 0;
  logic [WA-1:0] ld_waddr = '0;
  logic [NB-1:0] ld_strb = '0;
  logic          ld_ready, ld_rsp_valid;
  logic [DW-1:0] ld_rsp_data;
  logic          mem_wr_valid, mem_wr_ready = 1'b1;
  logic [WA-1:0] mem_wr_waddr;
  logic [NB-1:0] mem_wr_strb;
  logic [DW-1:0] mem_wr_data;
  logic          mem_rd_valid;
  logic          mem_rd_ready = 1'b1;
  logic [WA-1:0] mem_rd_waddr;
  logic          mem_rd_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rd_rsp_data = '0;
  logic          flush = 1'b0;
  logic          idle;

  merging_store_buffer #(.DEPTH(DEPTH), .WADDR_W(WA), .NB(NB)) u_merging_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_waddr(st_waddr), .st_strb(st_strb),
    .st_data(st_data), .st_dev(st_dev),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_waddr(ld_waddr), .ld_strb(ld_strb),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_waddr(mem_wr_waddr),
    .mem_wr_strb(mem_wr_strb), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_waddr(mem_rd_waddr),
    .mem_rd_rsp_valid(mem_rd_rsp_valid), .mem_rd_rsp_data(mem_rd_rsp_data),
    .flush(flush), .idle(idle)
  );

  // memory model (16 words) and program-order reference
  logic [DW-1:0] dmem [16];
  logic [DW-1:0] rmem [16];
  logic [WA-1:0] wr_log [16];
  int            wr_cnt = 0;
  int            rd_cnt = 0;
  logic          rd_pend = 1'b0;
  logic [3:0]    rd_idx = '0;

  always @(posedge clk) begin
    if (mem_wr_valid && mem_wr_ready) begin
      for (int b = 0; b < NB; b++)
        if (mem_wr_strb[b]) dmem[mem_wr_waddr[3:0]][b*8 +: 8] <= mem_wr_data[b*8 +: 8];
      wr_log[wr_cnt[3:0]] <= mem_wr_waddr;
      wr_cnt <= wr_cnt + 1;
    end
    rd_pend          <= mem_rd_valid && mem_rd_ready;
    if (mem_rd_valid && mem_rd_ready) begin
      rd_idx <= mem_rd_waddr[3:0];
      rd_cnt <= rd_cnt + 1;
    end
    mem_rd_rsp_valid <= rd_pend;
    mem_rd_rsp_data  <= dmem[rd_idx];
  end

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lanes(input logic [DW-1:0] d, input logic [NB-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) r[b*8 +: 8] = m[b] ? d[b*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic store(input logic [WA-1:0] a, input logic [NB-1:0] s,
                       input logic [DW-1:0] d, input bit dv);
    @(negedge clk);
    st_valid = 1; st_waddr = a; st_strb = s; st_data = d; st_dev = dv;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    for (int b = 0; b < NB; b++) if (s[b]) rmem[a[3:0]][b*8 +: 8] = d[b*8 +: 8];
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic probe_stall(input logic [WA-1:0] a, input logic [NB-1:0] s,
                             input bit dv, input string req);
    @(negedge clk);
    st_valid = 1; st_waddr = a; st_strb = s; st_data = '1; st_dev = dv;
    #1;
    chk(st_ready == 1'b0, req, DW'(st_ready), 0);
    @(negedge clk); #1;
    chk(st_ready == 1'b0, req, DW'(st_ready), 0);
    st_valid = 0;
  endtask

  task automatic load(input logic [WA-1:0] a, input logic [NB-1:0] s,
                      input bit via_fwd, input string req);
    int r0;
    int w;
    logic [DW-1:0] exp;
    r0 = rd_cnt;
    @(negedge clk);
    ld_valid = 1; ld_waddr = a; ld_strb = s;
    #1;
    while (!ld_ready) begin @(negedge clk); #1; end
    exp = lanes(rmem[a[3:0]], s);
    @(negedge clk);
    ld_valid = 0;
    if (via_fwd) begin
      chk(ld_rsp_valid == 1'b1, {req, " fwd response timing"}, DW'(ld_rsp_valid), 1);
    end else begin
      w = 0;
      while (!ld_rsp_valid && w < 50) begin @(negedge clk); w++; end
    end
    chk(ld_rsp_data == exp, {req, " load data"}, ld_rsp_data, exp);
    chk((rd_cnt - r0) == (via_fwd ? 0 : 1), {req, " memory reads"},
        DW'(rd_cnt - r0), DW'(via_fwd ? 0 : 1));
  endtask

  task automatic do_flush(input string req);
    int w;
    @(negedge clk);
    flush = 1;
    w = 0;
    while (!idle && w < 100) begin @(negedge clk); w++; end
    chk(idle == 1'b1, {req, " idle after flush"}, DW'(idle), 1);
    flush = 0;
  endtask

  task automatic t_reset;
    chk(idle == 1 && st_ready == 1, "R1 idle/st_ready", DW'({idle, st_ready}), 3);
    chk(!mem_wr_valid && !mem_rd_valid && !ld_rsp_valid, "R1 outputs quiet",
        DW'({mem_wr_valid, mem_rd_valid, ld_rsp_valid}), 0);
  endtask

  task automatic t_merge;
    int w0;
    w0 = wr_cnt;
    store(29'd2, 8'hFF, 64'h1111_2222_3333_4444, 0);
    store(29'd2, 8'h04, 64'h0000_0000_00AB_0000, 0);
    chk(wr_cnt == w0, "R5 lazy: no write yet", DW'(wr_cnt - w0), 0);
    load(29'd2, 8'h0C, 1, "R7 R3 straddle");
    do_flush("R11");
    chk(wr_cnt - w0 == 1, "R3 single merged write", DW'(wr_cnt - w0), 1);
    chk(dmem[2] == rmem[2], "R10 merged memory", dmem[2], rmem[2]);
  endtask

  task automatic t_device;
    int w0;
    w0 = wr_cnt;
    store(29'd3, 8'h01, 64'h0000_0000_0000_0055, 1);
    store(29'd3, 8'h02, 64'h0000_0000_0000_6600, 1);
    repeat (6) @(negedge clk);
    chk(wr_cnt - w0 == 2, "R4 R5 device writes eager and separate", DW'(wr_cnt - w0), 2);
    chk(idle == 1'b1, "R11 idle after device drain", DW'(idle), 1);
    chk(dmem[3] == rmem[3], "R10 device memory", dmem[3], rmem[3]);
  endtask

  task automatic t_full;
    int w0;
    logic [WA-1:0] a0;
    w0 = wr_cnt;
    mem_wr_ready = 0;
    for (int i = 0; i < 4; i++) store(WA'(8 + i), 8'hFF, {8{8'(8'h80 + i)}}, 0);
    @(negedge clk); #1;
    chk(mem_wr_valid == 1'b1, "R5 full triggers drain", DW'(mem_wr_valid), 1);
    chk(mem_wr_waddr == 29'd8, "R5 oldest first", DW'(mem_wr_waddr), 8);
    a0 = mem_wr_waddr;
    probe_stall(29'd12, 8'hFF, 0, "R2 full stall");
    chk(mem_wr_valid && mem_wr_waddr == a0, "R6 held payload", DW'(mem_wr_waddr), DW'(a0));
    store(29'd10, 8'h01, 64'h0000_0000_0000_00EE, 0);
    probe_stall(29'd8, 8'h01, 0, "R3 held head not merged");
    mem_wr_ready = 1;
    do_flush("R11");
    chk(wr_cnt - w0 == 4, "R3 merge adds no write", DW'(wr_cnt - w0), 4);
    for (int i = 0; i < 4; i++)
      chk(wr_log[4'(w0 + i)] == WA'(8 + i), "R5 allocation order",
          DW'(wr_log[4'(w0 + i)]), DW'(8 + i));
  endtask

  task automatic t_miss;
    load(29'd13, 8'hF0, 0, "R8 uncovered load");
  endtask

  task automatic t_partial;
    int w0;
    w0 = wr_cnt;
    store(29'd5, 8'h01, 64'h0000_0000_0000_00C3, 0);
    @(negedge clk);
    ld_valid = 1; ld_waddr = 29'd5; ld_strb = 8'h03;
    #1;
    chk(ld_ready == 1'b0, "R9 partial load held", DW'(ld_ready), 0);
    ld_valid = 0;
    load(29'd5, 8'h03, 0, "R9 partial completes");
    chk(wr_cnt - w0 == 1, "R9 drain before read", DW'(wr_cnt - w0), 1);
  endtask

  task automatic t_newest;
    int w0;
    w0 = wr_cnt;
    mem_wr_ready = 0;
    store(29'd7, 8'h0F, 64'h0000_0000_4433_2211, 0);
    store(29'd7, 8'h01, 64'h0000_0000_0000_0099, 1);
    load(29'd7, 8'h03, 1, "R7 newest across entries");
    store(29'd7, 8'h01, 64'h0000_0000_0000_0077, 0);
    load(29'd7, 8'h01, 1, "R4 no merge into device entry");
    mem_wr_ready = 1;
    do_flush("R11");
    chk(wr_cnt - w0 == 3, "R4 three writes", DW'(wr_cnt - w0), 3);
    chk(dmem[7] == rmem[7], "R10 program order", dmem[7], rmem[7]);
  endtask

  task automatic t_flush;
    store(29'd6, 8'hF0, 64'hDEAD_BEEF_0000_0000, 0);
    chk(idle == 1'b0, "R11 idle low when holding", DW'(idle), 0);
    @(negedge clk);
    flush = 1;
    #1;
    chk(st_ready == 1'b0, "R2 flush blocks stores", DW'(st_ready), 0);
    flush = 0;
    do_flush("R11");
    chk(dmem[6] == rmem[6], "R11 flushed data", dmem[6], rmem[6]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      dmem[i] = {8{8'(i * 17 + 3)}} ^ 64'h0123_4567_89AB_CDEF;
      rmem[i] = dmem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_merge();
    t_device();
    t_full();
    t_miss();
    t_partial();
    t_newest();
    t_flush();
    for (int i = 0; i < 16; i++)
      chk(dmem[i] == rmem[i], "R10 final memory", dmem[i], rmem[i]);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule